// File: doc/BRIEF.md
# Low-Power Port Match Wake Detector

This block watches a bank of digital input pins while the chip sleeps in one of two ultra-low-power modes, and produces a wake event on every cycle in which an enabled pin sits at the programmed level. The pins are grouped into four 8-bit ports. They are numbered flat: pin index = 8 x port + bit, so port 3 bit 3 is pin 27. Each pin's enable bit lives in a 16-byte mask memory that software fills through a plain byte-write interface. Only two bits of each byte are used.

A mode input selects between two modes. In the clock-only mode every pin can take part. In the display mode only the upper five pins of the last port can take part. A single polarity bit picks high-level or low-level matching for all pins at once. When the display is 4-way multiplexed, the block always uses high-level matching.

Matching is armed by a request to enter low-power mode while the enable input is set, and it is disarmed by the wake input. A sticky status flag records that a match has occurred, and software clears it by writing 1. An interrupt pulse follows either a low-power match or an external active-mode match. The write interface, the control inputs and the status outputs are plain level or pulse signals: the memory accepts a write in every cycle, so the block has no back-pressure and no valid/ready handshake.

Top module: `lp_pinwake`

## Requirements
- R1: After reset, all mask bits are 0, and `armed`, `lp_status`, `irq` and `match_evt` are all 0.
- R2: A write to word n stores data bit 3 as the mask of pin 2n and data bit 7 as the mask of pin 2n+1. All other data bits have no effect. A mask bit of 0 blocks its pin and a mask bit of 1 allows it.
- R3: With `lcd_mode`=0 (clock-only mode), all 32 pins (indices 0 to 31) can produce matches.
- R4: With `lcd_mode`=1 (display mode), only pins 27 to 31 can produce matches. Pin 26, whose mask is word 13 bit 3, never matches in this mode.
- R5: With `polarity`=1, a pin matches when it is high. With `polarity`=0, a pin matches when it is low. The same polarity applies to every pin.
- R6: With `lcd_mode`=1 and `mux4`=1, matching is high-level whatever the value of `polarity`.
- R7: Matching is level-sensitive. `match_evt` is 1 in every cycle in which the block is armed and some participating, unmasked pin equals the polarity level. The pins pass through two synchronizer flops, so a pin change reaches `match_evt` after two rising clock edges.
- R8: A pulse on `lp_enter` with `lp_enable`=1 sets `armed` at the next edge. A pulse on `lp_enter` with `lp_enable`=0 leaves `armed` unchanged. A pulse on `wake` clears `armed` and takes priority over `lp_enter` in the same cycle. While `armed` is 0, `match_evt` stays 0.
- R9: A pulse on `lp_rst` clears every mask bit at the next edge. It takes priority over a write in the same cycle.
- R10: `lp_status` is set at the edge after any cycle with `match_evt`=1. It stays set until a cycle with `stat_clr`=1 and no match, which clears it at the next edge. If a match and a clear fall in the same cycle, the match wins.
- R11: `irq` is 1 for one cycle after each cycle in which `match_evt` or `active_match` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_we | input | 1 | Mask memory write strobe |
| mem_addr | input | 4 | Mask memory word address |
| mem_wdata | input | 8 | Mask memory write byte |
| lp_rst | input | 1 | Pulse that clears all mask bits |
| lp_enable | input | 1 | Allows arming on entry to low-power mode |
| lp_enter | input | 1 | Pulse: low-power mode is being entered |
| wake | input | 1 | Pulse: leaving low-power mode, disarms matching |
| lcd_mode | input | 1 | 0 = clock-only mode, 1 = display mode |
| mux4 | input | 1 | Display is 4-way multiplexed |
| polarity | input | 1 | 1 = match high level, 0 = match low level |
| pins | input | 32 | Watched pins, index 8 x port + bit |
| active_match | input | 1 | Match event from active-mode logic |
| stat_clr | input | 1 | Write-1 clear of the status flag |
| match_evt | output | 1 | Low-power match this cycle |
| armed | output | 1 | Matching is armed |
| lp_status | output | 1 | Sticky low-power match flag |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench targets the mask bit mapping with bytes that set only the unused bits, so a design that decodes the wrong bit position, or swaps the even and odd pins, would match the wrong pin. It checks pin 26 and pins below 27 in display mode, where a design that used the whole mask would raise false wakes. It checks the 4-way multiplexed case with polarity 0, where a design that did not force high-level matching would wake on low pins. It also covers same-cycle collisions (wake with enter, reset with write, match with clear), and it counts exact cycles of latency, so a missing or extra synchronizer stage shows up as a one-cycle offset.

// File: rtl/lp_pinwake_pkg.sv
package lp_pinwake_pkg;
  typedef enum logic {
    MODE_CLOCK = 1'b0,
    MODE_LCD   = 1'b1
  } lp_mode_e;

  localparam int EVEN_MASK_BIT = 3;
  localparam int ODD_MASK_BIT  = 7;
endpackage

// File: rtl/lp_pinwake_maskmem.sv
module lp_pinwake_maskmem #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  output logic [NUM_PINS-1:0] mask
);
  import lp_pinwake_pkg::*;
  localparam int WORDS = NUM_PINS / 2;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[2*w]   <= 1'b0;
        mask[2*w+1] <= 1'b0;
      end else if (clr) begin
        mask[2*w]   <= 1'b0;
        mask[2*w+1] <= 1'b0;
      end else if (we && (int'(addr) == w)) begin
        mask[2*w]   <= wdata[EVEN_MASK_BIT];
        mask[2*w+1] <= wdata[ODD_MASK_BIT];
      end
    end
  end
endmodule

// File: rtl/lp_pinwake_sync.sv
module lp_pinwake_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/lp_pinwake_match.sv
module lp_pinwake_match #(
  parameter int NUM_PINS   = 32,
  parameter int PORT_W     = 8,
  parameter int LCD_LO_BIT = 3
) (
  input  logic                         armed,
  input  lp_pinwake_pkg::lp_mode_e     mode,
  input  logic                         mux4,
  input  logic                         polarity,
  input  logic [NUM_PINS-1:0]          mask,
  input  logic [NUM_PINS-1:0]          pins_s,
  output logic                         hit
);
  import lp_pinwake_pkg::*;
  localparam int LCD_BASE = NUM_PINS - PORT_W + LCD_LO_BIT;

  logic [NUM_PINS-1:0] lcd_part;
  logic [NUM_PINS-1:0] part;
  logic [NUM_PINS-1:0] level_ok;
  logic                eff_pol;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_part
    assign lcd_part[i] = (i >= LCD_BASE);
  end

  always_comb begin
    eff_pol  = (mode == MODE_LCD && mux4) ? 1'b1 : polarity;
    part     = (mode == MODE_LCD) ? lcd_part : {NUM_PINS{1'b1}};
    level_ok = eff_pol ? pins_s : ~pins_s;
    hit      = armed && (|(mask & part & level_ok));
  end
endmodule

// File: rtl/lp_pinwake.sv
module lp_pinwake #(
  parameter int NUM_PORTS   = 4,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LCD_LO_BIT  = 3,
  localparam int NUM_PINS   = NUM_PORTS * PORT_W,
  localparam int ADDR_W     = $clog2(NUM_PINS / 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mem_we,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic [7:0]          mem_wdata,
  input  logic                lp_rst,
  input  logic                lp_enable,
  input  logic                lp_enter,
  input  logic                wake,
  input  logic                lcd_mode,
  input  logic                mux4,
  input  logic                polarity,
  input  logic [NUM_PINS-1:0] pins,
  input  logic                active_match,
  input  logic                stat_clr,
  output logic                match_evt,
  output logic                armed,
  output logic                lp_status,
  output logic                irq
);
  import lp_pinwake_pkg::*;

  logic [NUM_PINS-1:0] mask;
  logic [NUM_PINS-1:0] pins_s;
  lp_mode_e            mode;

  assign mode = lp_mode_e'(lcd_mode);

  lp_pinwake_maskmem #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .clr(lp_rst), .we(mem_we),
    .addr(mem_addr), .wdata(mem_wdata), .mask(mask)
  );

  lp_pinwake_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pins_s)
  );

  lp_pinwake_match #(.NUM_PINS(NUM_PINS), .PORT_W(PORT_W), .LCD_LO_BIT(LCD_LO_BIT)) u_match (
    .armed(armed), .mode(mode), .mux4(mux4), .polarity(polarity),
    .mask(mask), .pins_s(pins_s), .hit(match_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      lp_status <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wake) armed <= 1'b0;
      else if (lp_enter && lp_enable) armed <= 1'b1;

      if (match_evt) lp_status <= 1'b1;
      else if (stat_clr) lp_status <= 1'b0;

      irq <= match_evt | active_match;
    end
  end
endmodule

// File: rtl/lp_pinwake_chk.sv
module lp_pinwake_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lp_rst,
  input logic                lp_enable,
  input logic                lp_enter,
  input logic                wake,
  input logic                lcd_mode,
  input logic                mux4,
  input logic                active_match,
  input logic                stat_clr,
  input logic                match_evt,
  input logic                armed,
  input logic                lp_status,
  input logic                irq,
  input logic [NUM_PINS-1:0] mask,
  input logic [NUM_PINS-1:0] pins_s
);
  a_r8_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_enter && lp_enable && !wake) |=> armed);
  a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !armed);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !match_evt);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    lp_rst |=> (mask == '0));
  a_r6_high_only: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_mode && mux4 && match_evt) |-> (|pins_s[NUM_PINS-1:NUM_PINS-5]));
  a_r10_set: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> lp_status);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_status && !stat_clr) |=> lp_status);
  a_r11_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt || active_match) |=> irq);
  a_r11_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_evt && !active_match) |=> !irq);
endmodule

bind lp_pinwake lp_pinwake_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lp_rst(lp_rst), .lp_enable(lp_enable),
  .lp_enter(lp_enter), .wake(wake), .lcd_mode(lcd_mode), .mux4(mux4),
  .active_match(active_match), .stat_clr(stat_clr), .match_evt(match_evt),
  .armed(armed), .lp_status(lp_status), .irq(irq), .mask(mask), .pins_s(pins_s)
);

// File: tb/lp_pinwake_tb.sv
module lp_pinwake_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_we = 0, lp_rst = 0, lp_enable = 0, lp_enter = 0, wake = 0;
  logic lcd_mode = 0, mux4 = 0, polarity = 0, active_match = 0, stat_clr = 0;
  logic [3:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0;
  logic [NP-1:0] pins = '0;
  logic match_evt, armed, lp_status, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [NP-1:0] m_mask = '0, m_s1 = '0, m_s2 = '0;
  logic m_armed = 0, m_status = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_pinwake u_dut (
    .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .lp_rst(lp_rst), .lp_enable(lp_enable),
    .lp_enter(lp_enter), .wake(wake), .lcd_mode(lcd_mode), .mux4(mux4),
    .polarity(polarity), .pins(pins), .active_match(active_match),
    .stat_clr(stat_clr), .match_evt(match_evt), .armed(armed),
    .lp_status(lp_status), .irq(irq)
  );

  function automatic logic exp_match();
    logic [NP-1:0] part;
    logic pol;
    part = lcd_mode ? 32'hF800_0000 : 32'hFFFF_FFFF;
    pol = (lcd_mode && mux4) ? 1'b1 : polarity;
    return m_armed && (|(m_mask & part & (pol ? m_s2 : ~m_s2)));
  endfunction

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0b exp=%0b t=%0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic em;
    @(posedge clk);
    em = exp_match();
    m_s2 = m_s1;
    m_s1 = pins;
    if (lp_rst) m_mask = '0;
    else if (mem_we) begin
      m_mask[2*mem_addr] = mem_wdata[3];
      m_mask[2*mem_addr+1] = mem_wdata[7];
    end
    if (wake) m_armed = 0;
    else if (lp_enter && lp_enable) m_armed = 1;
    if (em) m_status = 1;
    else if (stat_clr) m_status = 0;
    m_irq = em | active_match;
    @(negedge clk);
    chk(tag, "match_evt", match_evt, exp_match());
    chk(tag, "armed", armed, m_armed);
    chk(tag, "lp_status", lp_status, m_status);
    chk(tag, "irq", irq, m_irq);
  endtask

  task automatic clear_pulses();
    mem_we = 0; lp_rst = 0; lp_enter = 0; wake = 0; stat_clr = 0; active_match = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d, input string tag);
    mem_we = 1; mem_addr = 4'(a); mem_wdata = d;
    step(tag);
    mem_we = 0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic arm(input string tag);
    lp_enable = 1; lp_enter = 1; step(tag); lp_enter = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", "match_evt", match_evt, 1'b0);
    chk("R1", "armed", armed, 1'b0);
    chk("R1", "lp_status", lp_status, 1'b0);
    chk("R1", "irq", irq, 1'b0);
    arm("R1");
    polarity = 1; pins = '1; run(4, "R1");
    polarity = 0; pins = '0; run(4, "R1");

    // R2: mask bit mapping
    polarity = 1; pins = '0;
    wr(2, 8'h08, "R2");
    pins = 32'h1 << 4; run(4, "R2");
    pins = 32'h1 << 5; run(4, "R2");
    wr(2, 8'h80, "R2"); run(3, "R2");
    wr(2, 8'h77, "R2"); pins = 32'h30; run(4, "R2");

    // R3: clock-only mode, all pins
    for (int w = 0; w < 16; w++) wr(w, 8'h88, "R3");
    pins = 32'h1; run(3, "R3");
    pins = 32'h8000_0000; run(3, "R3");
    pins = 32'h0001_0000; run(3, "R3");

    // R4: display mode participation
    lcd_mode = 1;
    pins = 32'h1 << 26; run(4, "R4");
    pins = 32'h03FF_FFFF; run(4, "R4");
    pins = 32'h1 << 27; run(4, "R4");
    pins = 32'h1 << 31; run(3, "R4");

    // R5: low-level polarity
    polarity = 0; mux4 = 0;
    pins = ~(32'h1 << 29); run(4, "R5");
    pins = '1; run(4, "R5");
    lcd_mode = 0; pins = ~(32'h1 << 3); run(4, "R5");
    pins = '1; run(3, "R5");

    // R6: 4-way mux forces high-level matching
    lcd_mode = 1; mux4 = 1; polarity = 0;
    pins = 32'h07FF_FFFF; run(4, "R6");
    pins = 32'h1 << 30; run(4, "R6");
    mux4 = 0; pins = '0;

    // R7: level-sensitive, repeats every cycle, two-edge latency
    lcd_mode = 0; polarity = 1; pins = '0; run(3, "R7");
    pins = 32'h100; run(6, "R7");
    pins = '0; run(3, "R7");

    // R8: arming rules
    pins = '1; run(3, "R8");
    wake = 1; step("R8"); wake = 0; run(3, "R8");
    lp_enable = 0; lp_enter = 1; step("R8"); lp_enter = 0; run(2, "R8");
    lp_enable = 1; lp_enter = 1; wake = 1; step("R8"); clear_pulses(); run(2, "R8");
    arm("R8"); run(3, "R8");

    // R9: low-power reset clears masks, wins over a write
    mem_we = 1; mem_addr = 4'd5; mem_wdata = 8'h88; lp_rst = 1; step("R9");
    clear_pulses(); run(4, "R9");
    wr(5, 8'h88, "R9"); run(3, "R9");
    lp_rst = 1; step("R9"); lp_rst = 0; run(3, "R9");

    // R10: sticky status, write-1 clear, match wins
    wr(0, 8'h08, "R10"); pins = 32'h1; run(4, "R10");
    stat_clr = 1; step("R10"); stat_clr = 0;
    pins = '0; run(4, "R10");
    stat_clr = 1; step("R10"); stat_clr = 0; run(2, "R10");

    // R11: interrupt from active-mode match
    wake = 1; step("R11"); wake = 0;
    active_match = 1; step("R11"); active_match = 0; run(2, "R11");

    // Random mix (R7 level behaviour across all controls)
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      clear_pulses();
      mem_we = ($urandom % 4) == 0;
      mem_addr = 4'($urandom);
      mem_wdata = 8'($urandom);
      lp_rst = ($urandom % 64) == 0;
      lp_enable = ($urandom % 4) != 0;
      lp_enter = ($urandom % 16) == 0;
      wake = ($urandom % 24) == 0;
      if (($urandom % 32) == 0) lcd_mode = ~lcd_mode;
      if (($urandom % 32) == 0) mux4 = ~mux4;
      if (($urandom % 32) == 0) polarity = ~polarity;
      if (($urandom % 3) == 0) pins = polarity ? (32'h1 << ($urandom % 32)) : ~(32'h1 << ($urandom % 32));
      else if (($urandom % 3) == 0) pins = polarity ? '0 : '1;
      active_match = ($urandom % 16) == 0;
      stat_clr = ($urandom % 8) == 0;
      step("R7");
    end
    clear_pulses();
    run(2, "R7");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule